// File: doc/BRIEF.md
# Adder Carry-Chain Self-Test Sequencer

This block is a built-in self-test engine for an external N-bit ripple-carry adder. When it is started, it drives a fixed series of operand pairs into the adder. The pairs are chosen so that carries must travel through long stretches of the chain. For each pair it waits a fixed settle time. It then compares the adder's sum and carry-out with an (N+1)-bit reference sum that it computes itself. Every pair is applied twice: once in its natural order and once with the two operands swapped.

The families always run in the same order:

1. An all-ones word plus one.
2. Words that are all ones except for one zero, each plus one.
3. Single-one words added to all-ones.
4. A sweep that adds every power of two, and then zero, to every value of the other operand.
5. Words with two adjacent ones added to every value of the other operand.

At the end the block pulses `done` and reports either pass or fail. If the adder gave a wrong answer, the operands, the observed result, the expected result and the family of the first failing check are kept for inspection.

Top module: `adder_bist_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `done`, `pass` and `fail` are low and both operand outputs are zero. The only exception is that `pass` or `fail` keeps its last verdict until the next start.
- R2: In the natural order, `dut_a` carries the pattern word and `dut_b` the other word. The swapped order follows immediately with the two exchanged. Each order is held for SETTLE cycles (default N+1), and the adder result is sampled in the last of those cycles.
- R3: Families run in this order, with these 3-bit codes: all-ones (1), lone-zero (2), single-one (3), sweep (4), adjacent-pair (5). Within a family the position index is the outer loop and the swept value is the inner loop, both counting upward.
- R4: The all-ones family applies one vector, with pattern all-ones and other word 1.
- R5: The lone-zero family applies pattern ~(1<<k) with other word 1, for k = 0 to N-1.
- R6: The single-one family applies pattern 1<<k with other word all-ones, for k = 0 to N-1.
- R7: The sweep family applies pattern 1<<j for j = 0 to N-1 and then pattern 0. Each pattern is paired with every other word from 0 to 2^N-1.
- R8: The adjacent-pair family applies pattern 3<<p for p = 0 to N-2, each paired with every other word from 0 to 2^N-1.
- R9: A sample mismatches when {cout, sum} differs from the (N+1)-bit sum of the operands. A mismatch raises `fail`, which stays high until the next accepted start.
- R10: At the first mismatch, `rec_a`, `rec_b`, `rec_got`, `rec_exp` and `rec_fam` capture that sample. Later mismatches do not change them. An accepted start clears them to zero.
- R11: The cycle after the last sample, `done` is high for exactly one cycle. In that cycle `pass` is high exactly when no mismatch occurred in the run, and `fail` is high otherwise.
- R12: `start` is only accepted while the block is idle. Asserting it during a run does not change the vector sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test run when idle |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run finished with no mismatch |
| fail | output | 1 | At least one mismatch in the current or last run |
| dut_a | output | N | First operand to adder under test |
| dut_b | output | N | Second operand to adder under test |
| dut_sum | input | N | Sum from adder under test |
| dut_cout | input | 1 | Carry-out from adder under test |
| rec_a | output | N | First operand of first failing sample |
| rec_b | output | N | Second operand of first failing sample |
| rec_got | output | N+1 | Observed {cout,sum} of first failure |
| rec_exp | output | N+1 | Expected {cout,sum} of first failure |
| rec_fam | output | 3 | Family code of first failure |

## Verification
Several properties are checked on every cycle:
- The operands stay stable during each settle window.
- The operands are exchanged when the run moves to the swapped order.
- The `done` pulse is a single cycle and carries a consistent pass/fail verdict.
- `fail` is sticky, the failure record is frozen once captured, and the operands are quiet while idle.

Other behaviour needs the bench's scenarios:
- That the exact family order and pattern contents match the requirements.
- That a fault reached only in the swapped order is caught.
- That the record keeps the first failure and not a later one.
- That a start pulse in the middle of a run is ignored.

// File: rtl/bist_pkg.sv
// Shared types for the adder self-test sequencer.
// Assumes: family codes are stable; the codes are visible on the record port.
package bist_pkg;

    typedef enum logic [2:0] {
        FAM_IDLE     = 3'd0,
        FAM_ALLONES  = 3'd1,
        FAM_LONEZERO = 3'd2,
        FAM_LONEONE  = 3'd3,
        FAM_SWEEP    = 3'd4,
        FAM_LONEPAIR = 3'd5,
        FAM_DONE     = 3'd6
    } fam_e;

    // Successor of each family in the fixed test order.
    function automatic fam_e fam_next(input fam_e f);
        case (f)
            FAM_ALLONES:  return FAM_LONEZERO;
            FAM_LONEZERO: return FAM_LONEONE;
            FAM_LONEONE:  return FAM_SWEEP;
            FAM_SWEEP:    return FAM_LONEPAIR;
            FAM_LONEPAIR: return FAM_DONE;
            default:      return FAM_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/bist_pattern_gen.sv
// Pattern generator: maps (family, position index, swept value, order)
// to the operand pair, and reports the last index and value of the family.
// Assumes: N >= 2; IDXW can hold N; purely combinational.
module bist_pattern_gen
    import bist_pkg::*;
#(
    parameter int N    = 16,
    parameter int IDXW = $clog2(N + 2)
) (
    input  fam_e            fam,
    input  logic [IDXW-1:0] idx,
    input  logic [N-1:0]    val,
    input  logic            swap,
    output logic [N-1:0]    op_a,
    output logic [N-1:0]    op_b,
    output logic [IDXW-1:0] idx_last,
    output logic [N-1:0]    val_last
);
    localparam logic [N-1:0] ONE  = N'(1);
    localparam logic [N-1:0] PAIR = N'(3);
    localparam logic [N-1:0] ONES = '1;

    logic [N-1:0] pat;
    logic [N-1:0] oth;

    // Choose the pattern word and its partner for the current family.
    always_comb begin
        pat      = '0;
        oth      = '0;
        idx_last = '0;
        val_last = '0;
        case (fam)
            FAM_ALLONES: begin
                pat = ONES;
                oth = ONE;
            end
            FAM_LONEZERO: begin
                pat      = ~(ONE << idx);
                oth      = ONE;
                idx_last = IDXW'(N - 1);
            end
            FAM_LONEONE: begin
                pat      = ONE << idx;
                oth      = ONES;
                idx_last = IDXW'(N - 1);
            end
            FAM_SWEEP: begin
                pat      = (idx == IDXW'(N)) ? '0 : (ONE << idx);
                oth      = val;
                idx_last = IDXW'(N);
                val_last = ONES;
            end
            FAM_LONEPAIR: begin
                pat      = PAIR << idx;
                oth      = val;
                idx_last = IDXW'(N - 2);
                val_last = ONES;
            end
            default: begin
                pat = '0;
                oth = '0;
            end
        endcase
    end

    // Apply the operand order.
    always_comb begin
        op_a = swap ? oth : pat;
        op_b = swap ? pat : oth;
    end

endmodule

// File: rtl/bist_golden_cmp.sv
// Golden reference: forms the (N+1)-bit behavioural sum and compares it
// with the observed adder result. Assumes: combinational, no timing.
module bist_golden_cmp #(
    parameter int N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [N-1:0] sum,
    input  logic         cout,
    output logic [N:0]   expected,
    output logic [N:0]   observed,
    output logic         mismatch
);
    // Reference sum and comparison over all sum bits plus carry-out.
    always_comb begin
        expected = {1'b0, a} + {1'b0, b};
        observed = {cout, sum};
        mismatch = (expected != observed);
    end

endmodule

// File: rtl/bist_fail_record.sv
// First-failure record: latches one failing sample and a sticky fail flag.
// Assumes: clear has priority; capture is ignored once fail is set.
module bist_fail_record #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         capture,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [N:0]   got,
    input  logic [N:0]   exp,
    input  logic [2:0]   fam,
    output logic         fail,
    output logic [N-1:0] rec_a,
    output logic [N-1:0] rec_b,
    output logic [N:0]   rec_got,
    output logic [N:0]   rec_exp,
    output logic [2:0]   rec_fam
);
    // Hold the first failing sample until the next run is started.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail    <= 1'b0;
            rec_a   <= '0;
            rec_b   <= '0;
            rec_got <= '0;
            rec_exp <= '0;
            rec_fam <= '0;
        end else if (capture && !fail) begin
            fail    <= 1'b1;
            rec_a   <= a;
            rec_b   <= b;
            rec_got <= got;
            rec_exp <= exp;
            rec_fam <= fam;
        end
    end

endmodule

// File: rtl/adder_bist_seq.sv
// Adder carry-chain self-test sequencer (top).
// Walks the carry-stress families in fixed order, applies each vector in
// both operand orders, holds each for SETTLE cycles, samples in the last one.
// Assumes: the adder under test is combinational between dut_a/dut_b and
// dut_sum/dut_cout; N >= 2; SETTLE >= 1.
module adder_bist_seq
    import bist_pkg::*;
#(
    parameter int N      = 16,
    parameter int SETTLE = N + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic         done,
    output logic         pass,
    output logic         fail,
    output logic [N-1:0] dut_a,
    output logic [N-1:0] dut_b,
    input  logic [N-1:0] dut_sum,
    input  logic         dut_cout,
    output logic [N-1:0] rec_a,
    output logic [N-1:0] rec_b,
    output logic [N:0]   rec_got,
    output logic [N:0]   rec_exp,
    output logic [2:0]   rec_fam
);
    localparam int IDXW = $clog2(N + 2);
    localparam int WW   = (SETTLE < 2) ? 1 : $clog2(SETTLE);

    fam_e            fam_q;
    logic [IDXW-1:0] idx_q;
    logic [N-1:0]    val_q;
    logic            swap_q;
    logic [WW-1:0]   wait_q;
    logic            pass_q;

    logic [IDXW-1:0] idx_last;
    logic [N-1:0]    val_last;
    logic [N:0]      expected;
    logic [N:0]      observed;
    logic            mismatch;
    logic            running;
    logic            sample;
    logic            accept;

    bist_pattern_gen #(.N(N), .IDXW(IDXW)) u_pat (
        .fam      (fam_q),
        .idx      (idx_q),
        .val      (val_q),
        .swap     (swap_q),
        .op_a     (dut_a),
        .op_b     (dut_b),
        .idx_last (idx_last),
        .val_last (val_last)
    );

    bist_golden_cmp #(.N(N)) u_cmp (
        .a        (dut_a),
        .b        (dut_b),
        .sum      (dut_sum),
        .cout     (dut_cout),
        .expected (expected),
        .observed (observed),
        .mismatch (mismatch)
    );

    bist_fail_record #(.N(N)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (sample && mismatch),
        .a       (dut_a),
        .b       (dut_b),
        .got     (observed),
        .exp     (expected),
        .fam     (fam_q),
        .fail    (fail),
        .rec_a   (rec_a),
        .rec_b   (rec_b),
        .rec_got (rec_got),
        .rec_exp (rec_exp),
        .rec_fam (rec_fam)
    );

    // Decode run phase, sample point and start acceptance.
    always_comb begin
        running = (fam_q != FAM_IDLE) && (fam_q != FAM_DONE);
        sample  = running && (wait_q == WW'(SETTLE - 1));
        accept  = (fam_q == FAM_IDLE) && start;
        done    = (fam_q == FAM_DONE);
        pass    = pass_q;
    end

    // Sequencer: settle counter, operand order, value, index, family.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fam_q  <= FAM_IDLE;
            idx_q  <= '0;
            val_q  <= '0;
            swap_q <= 1'b0;
            wait_q <= '0;
            pass_q <= 1'b0;
        end else begin
            case (fam_q)
                FAM_IDLE: begin
                    if (start) begin
                        fam_q  <= FAM_ALLONES;
                        idx_q  <= '0;
                        val_q  <= '0;
                        swap_q <= 1'b0;
                        wait_q <= '0;
                        pass_q <= 1'b0;
                    end
                end
                FAM_DONE: begin
                    fam_q <= FAM_IDLE;
                end
                default: begin
                    if (!sample) begin
                        wait_q <= wait_q + 1'b1;
                    end else begin
                        wait_q <= '0;
                        if (!swap_q) begin
                            swap_q <= 1'b1;
                        end else begin
                            swap_q <= 1'b0;
                            if (val_q != val_last) begin
                                val_q <= val_q + 1'b1;
                            end else begin
                                val_q <= '0;
                                if (idx_q != idx_last) begin
                                    idx_q <= idx_q + 1'b1;
                                end else begin
                                    idx_q <= '0;
                                    fam_q <= fam_next(fam_q);
                                    if (fam_q == FAM_LONEPAIR)
                                        pass_q <= !(fail || mismatch);
                                end
                            end
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/bist_seq_checker.sv
// Protocol checker for adder_bist_seq, attached by bind.
// Assumes: rst_n is held low through the first clock edge.
module bist_seq_checker
    import bist_pkg::*;
#(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic         pass,
    input logic         fail,
    input logic [N-1:0] dut_a,
    input logic [N-1:0] dut_b,
    input logic [N-1:0] rec_a,
    input logic [N-1:0] rec_b,
    input logic [N:0]   rec_got,
    input logic [N:0]   rec_exp,
    input logic [2:0]   rec_fam,
    input logic [2:0]   state,
    input logic         running,
    input logic         sample,
    input logic         swap
);
    logic idle;
    assign idle = (state == FAM_IDLE);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (dut_a == '0 && dut_b == '0 && !done)); // R1

    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !sample) |=> ($stable(dut_a) && $stable(dut_b))); // R2

    AST_ORDER_SWAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && sample && !swap) |=>
            (dut_a == $past(dut_b) && dut_b == $past(dut_a))); // R2

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(idle && start)) |=> fail); // R9

    AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(idle && start)) |=> ($stable(rec_a) && $stable(rec_b) &&
            $stable(rec_got) && $stable(rec_exp) && $stable(rec_fam))); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_VERDICT_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass != fail)); // R11

    AST_START_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && !sample) |=> (state == $past(state))); // R12

endmodule

bind adder_bist_seq bist_seq_checker #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .pass    (pass),
    .fail    (fail),
    .dut_a   (dut_a),
    .dut_b   (dut_b),
    .rec_a   (rec_a),
    .rec_b   (rec_b),
    .rec_got (rec_got),
    .rec_exp (rec_exp),
    .rec_fam (rec_fam),
    .state   (fam_q),
    .running (running),
    .sample  (sample),
    .swap    (swap_q)
);

// File: tb/adder_bist_seq_test.sv
// Bench: behavioural schedule of expected operands, compared every cycle,
// with a bench-side adder that can inject faults.
module adder_bist_seq_test;
    localparam int N      = 4;
    localparam int SETTLE = N + 1;
    localparam logic [N-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         done, pass, fail;
    logic [N-1:0] dut_a, dut_b, dut_sum;
    logic         dut_cout;
    logic [N-1:0] rec_a, rec_b;
    logic [N:0]   rec_got, rec_exp;
    logic [2:0]   rec_fam;

    int fault_mode = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [N-1:0] qa[$];
    logic [N-1:0] qb[$];

    always #10 clk = ~clk;

    adder_bist_seq #(.N(N), .SETTLE(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
        .fail(fail), .dut_a(dut_a), .dut_b(dut_b), .dut_sum(dut_sum),
        .dut_cout(dut_cout), .rec_a(rec_a), .rec_b(rec_b),
        .rec_got(rec_got), .rec_exp(rec_exp), .rec_fam(rec_fam)
    );

    // Bench adder with optional faults.
    always_comb begin
        logic [N:0] r;
        r = {1'b0, dut_a} + {1'b0, dut_b};
        if (fault_mode == 1 && dut_a == N'(2) && dut_b == ONES) r = r ^ 1;
        if (fault_mode == 2 && dut_a == N'(1) && dut_b == ONES) r = r ^ 1;
        {dut_cout, dut_sum} = r;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_vec(input logic [N-1:0] p, input logic [N-1:0] o);
        for (int s = 0; s < SETTLE; s++) begin qa.push_back(p); qb.push_back(o); end
        for (int s = 0; s < SETTLE; s++) begin qa.push_back(o); qb.push_back(p); end
    endtask

    // Expected operand schedule, built from the requirements (R3..R8).
    task automatic build_schedule();
        qa.delete();
        qb.delete();
        push_vec(ONES, N'(1));                                   // R4
        for (int k = 0; k < N; k++) push_vec(~(N'(1) << k), N'(1)); // R5
        for (int k = 0; k < N; k++) push_vec(N'(1) << k, ONES);  // R6
        for (int j = 0; j <= N; j++)                             // R7
            for (int v = 0; v < (1 << N); v++)
                push_vec((j == N) ? '0 : (N'(1) << j), N'(v));
        for (int p = 0; p < N - 1; p++)                          // R8
            for (int v = 0; v < (1 << N); v++)
                push_vec(N'(3) << p, N'(v));
    endtask

    // One full run; per-cycle operand comparison (R2, R3, R12).
    task automatic run_once(input int fm, input bit expect_pass);
        int n;
        fault_mode = fm;
        build_schedule();
        n = qa.size();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk(dut_a == qa[i] && dut_b == qb[i], "R2/R3 operands",
                {dut_a, dut_b}, {qa[i], qb[i]});
            chk(!done, "R11 no early done", done, 0);
            if (i == 37) start = 1'b1;   // R12: start during a run
            if (i == 38) start = 1'b0;
            @(negedge clk);
        end
        chk(done, "R11 done pulse", done, 1);
        chk(pass == expect_pass, "R11 pass verdict", pass, expect_pass);
        chk(fail == !expect_pass, "R9 fail flag", fail, !expect_pass);
        @(negedge clk);
        chk(!done, "R11 done single cycle", done, 0);
        chk(dut_a == '0 && dut_b == '0, "R1 idle operands", {dut_a, dut_b}, 0);
        chk(pass == expect_pass, "R11 verdict held", pass, expect_pass);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !pass && !fail, "R1 reset flags", {done, pass, fail}, 0);
        chk(dut_a == '0 && dut_b == '0, "R1 reset operands", {dut_a, dut_b}, 0);

        run_once(0, 1'b1);
        chk(rec_fam == 3'd0 && rec_got == '0, "R10 record clear", rec_got, 0);

        // Fault in natural order of single-one k=1: A=2, B=ones.
        run_once(1, 1'b0);
        chk(rec_a == N'(2) && rec_b == ONES, "R10 record operands",
            {rec_a, rec_b}, {N'(2), ONES});
        chk(rec_exp == ((N + 1)'(2) + (N + 1)'(ONES)), "R9 record expected",
            rec_exp, (N + 1)'(2) + (N + 1)'(ONES));
        chk(rec_got == (((N + 1)'(2) + (N + 1)'(ONES)) ^ 1), "R9 record observed",
            rec_got, ((N + 1)'(2) + (N + 1)'(ONES)) ^ 1);
        chk(rec_fam == 3'd3, "R10 first failure family kept", rec_fam, 3);

        // Fault only in swapped order of the all-ones vector: A=1, B=ones.
        run_once(2, 1'b0);
        chk(rec_a == N'(1) && rec_b == ONES, "R2 swapped-order fault caught",
            {rec_a, rec_b}, {N'(1), ONES});
        chk(rec_fam == 3'd1, "R10 earliest record kept", rec_fam, 1);
        chk(rec_exp == (N + 1)'(1 << N), "R4 expected carry-out", rec_exp, 1 << N);

        // A clean run after a failure clears fail and record.
        run_once(0, 1'b1);
        chk(!fail && rec_a == '0, "R10 cleared by start", {fail, rec_a}, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule